// File: doc/BRIEF.md
# Paint Brush Cursor Engine

This block turns one packed game-controller status word into the state of a paint brush. The state is a cursor position, a brush size, a 32-bit colour, a painting level and a single-cycle canvas-clear command. Motion comes from the analog stick. The block samples the stick on a one-cycle frame strobe, so the cursor moves at most once per displayed frame. Two consumers use the outputs: a renderer that writes the area under the brush into memory, and a video path that draws the cursor.

Buttons do their work on a press, not while they are held. The colour button steps through an eight-entry palette and wraps around. The two size buttons grow or shrink the brush within 1 to 32 pixels. The erase button produces one clear pulse. The position is the top-left corner of the brush, and the block keeps the whole brush inside a canvas whose width and height are parameters.

A small state machine sequences the frame update. It has two states. `FS_IDLE` waits for the frame strobe. `FS_APPLY` adds the captured motion to the position. The transitions are:
- *capture* (`FS_IDLE` to `FS_APPLY`, on a strobe).
- *chain* (`FS_APPLY` to `FS_APPLY`, when a further strobe arrives at once).
- *settle* (`FS_APPLY` to `FS_IDLE`, when no strobe arrives).

Top module: `paint_brush_engine`

## Requirements
- R1: After reset the outputs take these values: cursor_x = CANVAS_W/2, cursor_y = CANVAS_H/2, brush_size = 1, brush_color = 32'hFF000000 (palette index 0), paint_active = 0 and clear_canvas = 0.
- R2: The status word has these fields. Bits 15:8 hold the signed stick X value and bits 7:0 the signed stick Y value. Bit 16 is paint, bit 17 is erase, bit 18 is colour step, bit 19 is grow and bit 20 is shrink. Bits 29:21 have no effect on any output.
- R3: The stick value is captured on the clock edge at which frame_strobe is high, and the position moves on the edge that follows. Without a strobe the position does not move, except for the size pull-in described in R7.
- R4: A stick value v with -8 < v < 8 gives no motion. Any other value moves X by v>>>4 (arithmetic shift) and moves Y by -(v>>>4), so a positive stick Y moves the cursor up the screen.
- R5: The position is always kept within 0 <= cursor_x <= CANVAS_W - brush_size and 0 <= cursor_y <= CANVAS_H - brush_size.
- R6: paint_active equals the paint flag as it was sampled on the previous clock edge.
- R7: A rising edge of grow adds 1 to the size and a rising edge of shrink subtracts 1. The size saturates at 1 and at 32. When both rise on the same edge the size does not change. On the edge where the size grows, the position is pulled back inside the canvas.
- R8: A rising edge of the colour flag advances the palette index i modulo 8. The colour is {8'hFF, R, G, B}, where R is 8'hFF if i[2] is set and 0 otherwise, G follows i[1] and B follows i[0].
- R9: clear_canvas is high for exactly one cycle, on the edge where the erase flag rises. Holding the flag down does not produce another pulse.
- R10: A flag that is already high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_status | input | 30 | Packed controller word: flags and stick values |
| frame_strobe | input | 1 | One-cycle pulse at the start of each frame |
| brush_color | output | 32 | Selected palette colour |
| cursor_x | output | $clog2(CANVAS_W) | Brush left column |
| cursor_y | output | $clog2(CANVAS_H) | Brush top row |
| brush_size | output | $clog2(SIZE_MAX+1) | Brush edge length in pixels |
| paint_active | output | 1 | Write the area under the brush |
| clear_canvas | output | 1 | One-cycle request to clear the canvas |

## Verification
The bench pushes the cursor into every wall at full stick deflection. A missing or off-by-one clamp would let the brush leave the canvas or wrap around to the far edge.

It grows the brush while the cursor is parked at the right and bottom edges. A design that clamps only on frame strobes would leave the brush hanging past the border for up to a frame.

Stick values of ±7 and ±8 probe the dead-zone edge. A design that shifts a negative value logically instead of arithmetically would send the cursor far away.

Held buttons, buttons held through reset, simultaneous grow and shrink, and back-to-back strobes each expose a design that triggers on levels or drops the second frame of a chained pair.

// File: rtl/paint_pkg.sv
package paint_pkg;

    typedef enum logic {
        FS_IDLE,
        FS_APPLY
    } frame_state_e;

    localparam int FLAG_LSB   = 16;
    localparam int FLAG_USED  = 5;
    localparam int BTN_PAINT  = 0;
    localparam int BTN_ERASE  = 1;
    localparam int BTN_COLOR  = 2;
    localparam int BTN_GROW   = 3;
    localparam int BTN_SHRINK = 4;

    localparam int STICK_W    = 8;
    localparam int STICK_X_LO = 8;
    localparam int STICK_Y_LO = 0;
    localparam int DEAD_ZONE  = 8;
    localparam int STEP_SHIFT = 4;
    localparam int DELTA_W    = STICK_W - STEP_SHIFT + 1;

    localparam int PAL_BITS   = 3;

    function automatic logic [31:0] palette_word(input logic [PAL_BITS-1:0] idx);
        return {8'hFF, {8{idx[2]}}, {8{idx[1]}}, {8{idx[0]}}};
    endfunction

endpackage

// File: rtl/frame_seq.sv
module frame_seq
    import paint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_strobe,
    output logic capture,
    output logic apply
);

    frame_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  state_d = frame_strobe ? FS_APPLY : FS_IDLE;
            FS_APPLY: state_d = frame_strobe ? FS_APPLY : FS_IDLE;
            default:  state_d = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        capture = 1'b0;
        apply   = 1'b0;
        unique case (state_q)
            FS_IDLE:  capture = frame_strobe;
            FS_APPLY: begin
                apply   = 1'b1;
                capture = frame_strobe;
            end
            default: ;
        endcase
    end

    AST_APPLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> $past(frame_strobe)); // R3

endmodule

// File: rtl/axis_mover.sv
module axis_mover
    import paint_pkg::*;
#(
    parameter int CANVAS    = 800,
    parameter int PW        = 10,
    parameter int SZW       = 6,
    parameter bit INVERT    = 1'b0,
    parameter int RESET_POS = 400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                apply,
    input  logic [STICK_W-1:0]  stick,
    input  logic [SZW-1:0]      size_next,
    output logic [PW-1:0]       pos
);

    localparam int AW = PW + 2;

    logic signed [STICK_W-1:0]         stick_s;
    logic signed [STICK_W-STEP_SHIFT-1:0] shifted;
    logic signed [DELTA_W-1:0]         delta_d, delta_q;
    logic signed [AW-1:0]              base, lim, res;
    logic [PW-1:0]                     pos_q;
    logic                              spare_unused;

    assign stick_s = stick;
    assign shifted = STICK_W'(stick_s >>> STEP_SHIFT) >>> 0 ;

    always_comb begin
        if (stick_s > -DEAD_ZONE && stick_s < DEAD_ZONE)
            delta_d = '0;
        else if (INVERT)
            delta_d = -DELTA_W'(shifted);
        else
            delta_d = DELTA_W'(shifted);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       delta_q <= '0;
        else if (capture) delta_q <= delta_d;
    end

    always_comb begin
        lim  = $signed(AW'(CANVAS)) - $signed({{(AW-SZW){1'b0}}, size_next});
        base = $signed({2'b00, pos_q});
        if (apply)
            base = base + {{(AW-DELTA_W){delta_q[DELTA_W-1]}}, delta_q};
        if (base < 0)        res = '0;
        else if (base > lim) res = lim;
        else                 res = base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= PW'(RESET_POS);
        else        pos_q <= res[PW-1:0];
    end

    assign spare_unused = ^res[AW-1:PW];
    assign pos = pos_q;

    AST_POS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply && ($signed({2'b00, pos_q}) <= lim)) |=> $stable(pos_q)); // R3

endmodule

// File: rtl/btn_edge_unit.sv
module btn_edge_unit
    import paint_pkg::*;
#(
    parameter int NFLAG = FLAG_USED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] btn,
    output logic [NFLAG-1:0] rise,
    output logic             paint_q,
    output logic             clear_q
);

    logic [NFLAG-1:0] prev_q;

    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[f] <= 1'b1;
            else        prev_q[f] <= btn[f];
        end
        assign rise[f] = btn[f] & ~prev_q[f];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paint_q <= 1'b0;
            clear_q <= 1'b0;
        end else begin
            paint_q <= btn[BTN_PAINT];
            clear_q <= rise[BTN_ERASE];
        end
    end

    AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clear_q |=> !clear_q); // R9
    AST_CLEAR_NEEDS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clear_q) |-> $past(btn[BTN_ERASE])); // R9

endmodule

// File: rtl/brush_attr_unit.sv
module brush_attr_unit
    import paint_pkg::*;
#(
    parameter int SIZE_MIN = 1,
    parameter int SIZE_MAX = 32,
    parameter int SZW      = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           color_rise,
    input  logic           grow_rise,
    input  logic           shrink_rise,
    output logic [SZW-1:0] size_q,
    output logic [SZW-1:0] size_next,
    output logic [31:0]    color
);

    logic [PAL_BITS-1:0] idx_q;

    always_comb begin
        size_next = size_q;
        if (grow_rise && !shrink_rise && size_q < SZW'(SIZE_MAX))
            size_next = size_q + 1'b1;
        else if (shrink_rise && !grow_rise && size_q > SZW'(SIZE_MIN))
            size_next = size_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SZW'(SIZE_MIN);
            idx_q  <= '0;
        end else begin
            size_q <= size_next;
            if (color_rise) idx_q <= idx_q + 1'b1;
        end
    end

    assign color = palette_word(idx_q);

    AST_SIZE_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q >= SZW'(SIZE_MIN)) && (size_q <= SZW'(SIZE_MAX))); // R7
    AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !color_rise |=> $stable(color)); // R8
    AST_SIZE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (grow_rise && shrink_rise) |=> $stable(size_q)); // R7

endmodule

// File: rtl/paint_brush_engine.sv
module paint_brush_engine
    import paint_pkg::*;
#(
    parameter int CANVAS_W = 800,
    parameter int CANVAS_H = 600,
    parameter int SIZE_MIN = 1,
    parameter int SIZE_MAX = 32,
    localparam int XW  = $clog2(CANVAS_W),
    localparam int YW  = $clog2(CANVAS_H),
    localparam int SZW = $clog2(SIZE_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [29:0]    ctrl_status,
    input  logic           frame_strobe,
    output logic [31:0]    brush_color,
    output logic [XW-1:0]  cursor_x,
    output logic [YW-1:0]  cursor_y,
    output logic [SZW-1:0] brush_size,
    output logic           paint_active,
    output logic           clear_canvas
);

    logic                 capture, apply;
    logic [FLAG_USED-1:0] flags, rise;
    logic [SZW-1:0]       size_next;
    logic                 spare_unused;

    assign flags        = ctrl_status[FLAG_LSB +: FLAG_USED];
    assign spare_unused = ^{ctrl_status[29:FLAG_LSB+FLAG_USED], rise[BTN_PAINT], rise[BTN_ERASE]};

    frame_seq i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .capture      (capture),
        .apply        (apply)
    );

    btn_edge_unit #(.NFLAG(FLAG_USED)) i_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn     (flags),
        .rise    (rise),
        .paint_q (paint_active),
        .clear_q (clear_canvas)
    );

    brush_attr_unit #(
        .SIZE_MIN (SIZE_MIN),
        .SIZE_MAX (SIZE_MAX),
        .SZW      (SZW)
    ) i_attr (
        .clk         (clk),
        .rst_n       (rst_n),
        .color_rise  (rise[BTN_COLOR]),
        .grow_rise   (rise[BTN_GROW]),
        .shrink_rise (rise[BTN_SHRINK]),
        .size_q      (brush_size),
        .size_next   (size_next),
        .color       (brush_color)
    );

    axis_mover #(
        .CANVAS    (CANVAS_W),
        .PW        (XW),
        .SZW       (SZW),
        .INVERT    (1'b0),
        .RESET_POS (CANVAS_W / 2)
    ) i_axis_x (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .apply     (apply),
        .stick     (ctrl_status[STICK_X_LO +: STICK_W]),
        .size_next (size_next),
        .pos       (cursor_x)
    );

    axis_mover #(
        .CANVAS    (CANVAS_H),
        .PW        (YW),
        .SZW       (SZW),
        .INVERT    (1'b1),
        .RESET_POS (CANVAS_H / 2)
    ) i_axis_y (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .apply     (apply),
        .stick     (ctrl_status[STICK_Y_LO +: STICK_W]),
        .size_next (size_next),
        .pos       (cursor_y)
    );

    AST_BRUSH_INSIDE_X: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cursor_x) + int'(brush_size)) <= CANVAS_W); // R5
    AST_BRUSH_INSIDE_Y: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cursor_y) + int'(brush_size)) <= CANVAS_H); // R5
    AST_PAINT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paint_active) |-> $past(ctrl_status[FLAG_LSB + BTN_PAINT])); // R6

endmodule

// File: tb/test_paint_brush_engine.sv
module test_paint_brush_engine;

    localparam int W = 800;
    localparam int H = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] status = '0;
    logic        strobe = 1'b0;
    logic [31:0] color;
    logic [9:0]  cx, cy;
    logic [5:0]  sz;
    logic        paint, clr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    int       m_x, m_y, m_size, m_col, m_dx, m_dy;
    bit       m_apply, m_paint, m_clear;
    bit [4:0] m_prev;

    always #2.5 clk = ~clk;

    paint_brush_engine i_paint_brush_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_status  (status),
        .frame_strobe (strobe),
        .brush_color  (color),
        .cursor_x     (cx),
        .cursor_y     (cy),
        .brush_size   (sz),
        .paint_active (paint),
        .clear_canvas (clr)
    );

    function automatic int stick_delta(logic [7:0] v, bit inv);
        int s = int'($signed(v));
        int d;
        if (s > -8 && s < 8) return 0;
        d = (s >= 0) ? (s / 16) : -((-s + 15) / 16);
        return inv ? -d : d;
    endfunction

    function automatic int clampi(int v, int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [31:0] exp_color(int i);
        logic [2:0] b = 3'(i);
        return {8'hFF, b[2] ? 8'hFF : 8'h00, b[1] ? 8'hFF : 8'h00, b[0] ? 8'hFF : 8'h00};
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_x = W / 2; m_y = H / 2; m_size = 1; m_col = 0;
        m_dx = 0; m_dy = 0; m_apply = 0; m_paint = 0; m_clear = 0;
        m_prev = 5'h1F;
    endtask

    task automatic compare_all();
        check("R5 cursor_x", 32'(cx), 32'(m_x));
        check("R5 cursor_y", 32'(cy), 32'(m_y));
        check("R7 size", 32'(sz), 32'(m_size));
        check("R8 color", color, exp_color(m_col));
        check("R6 paint", 32'(paint), 32'(m_paint));
        check("R9 clear", 32'(clr), 32'(m_clear));
    endtask

    task automatic step();
        bit [4:0] b, r;
        @(posedge clk);
        b = status[20:16];
        r = b & ~m_prev;
        m_prev = b;
        if (r[3] && !r[4] && m_size < 32) m_size++;
        else if (r[4] && !r[3] && m_size > 1) m_size--;
        if (r[2]) m_col = (m_col + 1) % 8;
        m_clear = r[1];
        m_paint = b[0];
        m_x = clampi(m_x + (m_apply ? m_dx : 0), W - m_size);
        m_y = clampi(m_y + (m_apply ? m_dy : 0), H - m_size);
        m_apply = strobe;
        if (strobe) begin
            m_dx = stick_delta(status[15:8], 1'b0);
            m_dy = stick_delta(status[7:0], 1'b1);
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset(logic [29:0] held);
        @(negedge clk);
        rst_n  = 1'b0;
        status = held;
        strobe = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic frame(logic [7:0] sx, logic [7:0] sy);
        status[15:8] = sx; status[7:0] = sy; strobe = 1'b1;
        step();
        strobe = 1'b0;
        step();
    endtask

    task automatic press(int bitpos);
        status[bitpos] = 1'b1; step();
        status[bitpos] = 1'b0; step();
    endtask

    initial begin
        int keep_x, keep_y;
        void'($urandom(32'h0BAD_5EED));
        do_reset('0);
        // R1 reset values
        check("R1 x", 32'(cx), W / 2);
        check("R1 y", 32'(cy), H / 2);
        check("R1 size", 32'(sz), 1);
        check("R1 color", color, 32'hFF00_0000);
        check("R1 paint", 32'(paint), 0);
        check("R1 clear", 32'(clr), 0);

        // R2 upper flag bits have no effect
        status[29:21] = 9'h1FF; step(); step();
        check("R2 paint", 32'(paint), 0);
        check("R2 clear", 32'(clr), 0);
        check("R2 size", 32'(sz), 1);
        status[29:21] = '0;

        // R3 no motion without strobe
        keep_x = int'(cx);
        status[15:8] = 8'h7F; repeat (5) step();
        check("R3 hold", 32'(cx), 32'(keep_x));

        // R4 dead zone edges
        keep_x = int'(cx); keep_y = int'(cy);
        frame(8'h07, 8'hF9);
        check("R4 dz x", 32'(cx), 32'(keep_x));
        check("R4 dz y", 32'(cy), 32'(keep_y));
        frame(8'hF8, 8'h08);
        check("R4 neg x", 32'(cx), 32'(keep_x - 1));
        check("R4 pos y", 32'(cy), 32'(keep_y));

        // R5 walls, including chained strobes
        status[15:8] = 8'h7F; status[7:0] = 8'h80; strobe = 1'b1;
        repeat (120) step();
        strobe = 1'b0; step();
        check("R5 right", 32'(cx), W - 1);
        check("R5 bottom", 32'(cy), H - 1);

        // R7 growth at the wall pulls in, saturates at 32
        repeat (40) press(19);
        check("R7 max", 32'(sz), 32);
        check("R7 pull x", 32'(cx), W - 32);
        status[19] = 1'b1; status[20] = 1'b1; step();
        check("R7 both", 32'(sz), 32);
        status[20:19] = '0; step();
        repeat (40) press(20);
        check("R7 min", 32'(sz), 1);

        // R8 wrap
        repeat (9) press(18);
        check("R8 wrap", color, exp_color(1));

        // R9 held erase pulses once
        status[17] = 1'b1; step();
        check("R9 pulse", 32'(clr), 1);
        repeat (4) step();
        check("R9 held", 32'(clr), 0);
        status[17] = 1'b0; step();

        // R10 flag held through reset
        do_reset(30'h0002_0000);
        repeat (3) step();
        check("R10 no edge", 32'(clr), 0);
        status = '0; step();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            for (int f = 16; f <= 20; f++)
                if ($urandom_range(3) == 0) status[f] = ~status[f];
            status[29:21] = 9'($urandom);
            status[15:0]  = 16'($urandom);
            strobe = ($urandom_range(2) == 0);
            step();
        end
        strobe = 1'b0;
        step();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule